// File: doc/BRIEF.md
# Four-Phase Debug Bus Register Target

This block is a small bank of plain storage registers that sits behind a debug-module bus running a full four-phase request/acknowledge exchange, all in one system clock domain. A master raises `req_i` together with an address, a write flag and a write-data word. The target captures them in the first cycle it sees the request. After a configurable number of extra cycles it raises `ack_i`... more precisely `ack_o`, and it then holds both the acknowledge and the read data steady until the master withdraws the request.

The response latency is set by a parameter, zero included. Masters can therefore be exercised against both immediate and slow targets. Every address at or above the register count is unmapped. A read of an unmapped address returns zero, and a write to one is dropped. A synchronous reset clears the whole bank and the handshake.

Top module: `dbg_reg_target`

## Requirements
- R1: Address, write flag and write data are taken only at the rising edge where `req_i` is first sampled high from idle. Later changes to them while the request is open have no effect on the stored data or on `rdata_o`.
- R2: `ack_o` goes high after the edge that is LATENCY edges after the capture edge. In other words, it is first visible LATENCY+1 clock cycles after `req_i` was raised.
- R3: Once high, `ack_o` stays high for as long as `req_i` stays high.
- R4: `ack_o` is low in the first cycle after the edge where `req_i` is sampled low.
- R5: `rdata_o` does not change while `ack_o` is high.
- R6: With `wr_i`=1, the addressed register is written exactly once, on the capture edge. With `wr_i`=0, `rdata_o` returns the stored word.
- R7: An address value below NUM_REGS selects the register of that number. Reads of any higher address return zero, and writes to one are ignored.
- R8: Synchronous active-high `rst_i` clears every register and `rdata_o` to zero and forces `ack_o` low in the next cycle.
- R9: A new request raised after `req_i` has been low for one sampled edge is accepted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request from the master, held until acknowledged |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, held while acknowledged |
| ack_o | output | 1 | Acknowledge, held until the request drops |

## Verification
The following handshake rules are checked on every cycle:
- the acknowledge stays up while the request stays up, and drops the cycle after the request falls;
- the read data holds still while acknowledged;
- reset clears the outputs;
- the acknowledge rises exactly LATENCY+1 cycles into a request, measured by a counter in the checker.

What the registers hold can only be shown by the bench's scenarios: single-shot writes despite a long request, stores that ignore wiggled inputs, zero reads of unmapped space, and the cleared bank after reset.

// File: rtl/dbgt_pkg.sv
package dbgt_pkg;
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_WAIT = 2'd1,
    HS_ACK  = 2'd2
  } hs_state_e;
endpackage

// File: rtl/dbgt_handshake.sv
module dbgt_handshake #(
  parameter int LATENCY = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic req_i,
  output logic start_o,
  output logic ack_o
);
  import dbgt_pkg::*;

  hs_state_e state_q;
  logic      ack_q;
  logic      wait_done;

  assign start_o = (state_q == HS_IDLE) && req_i;
  assign ack_o   = ack_q;

  generate
    if (LATENCY == 0) begin : g_nolat
      assign wait_done = 1'b1;
    end else begin : g_lat
      localparam int CNT_W = $clog2(LATENCY) + 1;
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk_i) begin
        if (rst_i || start_o) begin
          cnt_q <= '0;
        end else if (state_q == HS_WAIT) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      assign wait_done = (cnt_q == CNT_W'(LATENCY - 1));
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= HS_IDLE;
      ack_q   <= 1'b0;
    end else begin
      unique case (state_q)
        HS_IDLE: begin
          if (req_i) begin
            if (LATENCY == 0) begin
              state_q <= HS_ACK;
              ack_q   <= 1'b1;
            end else begin
              state_q <= HS_WAIT;
            end
          end
        end
        HS_WAIT: begin
          if (wait_done) begin
            state_q <= HS_ACK;
            ack_q   <= 1'b1;
          end
        end
        HS_ACK: begin
          if (!req_i) begin
            state_q <= HS_IDLE;
            ack_q   <= 1'b0;
          end
        end
        default: begin
          state_q <= HS_IDLE;
          ack_q   <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/dbgt_regbank.sv
module dbgt_regbank #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic              rd_hit_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [NUM_REGS];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        mem_q[i] <= '0;
      end
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rd_q <= '0;
    end else if (rd_en_i) begin
      rd_q <= rd_hit_i ? mem_q[rd_idx_i] : '0;
    end
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/dbg_reg_target.sv
module dbg_reg_target #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16,
  parameter int LATENCY  = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ack_o
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic             start;
  logic             hit;
  logic [IDX_W-1:0] idx;

  assign hit = ({1'b0, addr_i} < (ADDR_W + 1)'(NUM_REGS));
  assign idx = IDX_W'(addr_i);

  dbgt_handshake #(
    .LATENCY(LATENCY)
  ) hs_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .req_i  (req_i),
    .start_o(start),
    .ack_o  (ack_o)
  );

  dbgt_regbank #(
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS),
    .IDX_W   (IDX_W)
  ) bank_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .wr_en_i  (start && wr_i && hit),
    .wr_idx_i (idx),
    .wr_data_i(wdata_i),
    .rd_en_i  (start && !wr_i),
    .rd_hit_i (hit),
    .rd_idx_i (idx),
    .rd_data_o(rdata_o)
  );
endmodule

// File: rtl/dbg_reg_target_chk.sv
module dbg_reg_target_chk #(
  parameter int DATA_W  = 32,
  parameter int LATENCY = 2
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              req_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              ack_o
);
  logic [31:0] open_cnt;
  logic        ack_prev;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      open_cnt <= '0;
      ack_prev <= 1'b0;
    end else begin
      ack_prev <= ack_o;
      if (!req_i) begin
        open_cnt <= '0;
      end else if (!ack_o && open_cnt != 32'hFFFF_FFFF) begin
        open_cnt <= open_cnt + 1;
      end
    end
  end

  assert_ack_hold_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack_o && req_i) |=> ack_o);

  assert_ack_release_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack_o && !req_i) |=> !ack_o);

  assert_rdata_steady_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack_o && req_i) |=> $stable(rdata_o));

  assert_reset_clear_R8: assert property (@(posedge clk_i)
    rst_i |=> (!ack_o && rdata_o == '0));

  // R2: latency measured with a counter instead of a long $past
  assert_ack_latency_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack_o && !ack_prev) |-> (open_cnt == 32'(LATENCY + 1)));
endmodule

bind dbg_reg_target dbg_reg_target_chk #(
  .DATA_W (DATA_W),
  .LATENCY(LATENCY)
) chk_i (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .req_i  (req_i),
  .rdata_o(rdata_o),
  .ack_o  (ack_o)
);

// File: tb/dbg_reg_target_tb_top.sv
`timescale 1ns/1ps
module dbg_reg_target_tb_top;
  localparam int LAT  = 2;
  localparam int NREG = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ack;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dbg_reg_target #(
    .ADDR_W(8), .DATA_W(32), .NUM_REGS(NREG), .LATENCY(LAT)
  ) dut_i (
    .clk_i(clk), .rst_i(rst), .req_i(req), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .ack_o(ack)
  );

  // {wr, addr, wdata, expected read data}
  localparam logic [72:0] VEC [12] = '{
    {1'b0, 8'h03, 32'h0,         32'h0},
    {1'b1, 8'h03, 32'hDEADBEEF,  32'h0},
    {1'b0, 8'h03, 32'h0,         32'hDEADBEEF},
    {1'b1, 8'h0F, 32'hA5A50001,  32'h0},
    {1'b1, 8'h10, 32'h12345678,  32'h0},
    {1'b0, 8'h10, 32'h0,         32'h0},
    {1'b0, 8'h0F, 32'h0,         32'hA5A50001},
    {1'b1, 8'h00, 32'hFFFFFFFF,  32'h0},
    {1'b0, 8'h00, 32'h0,         32'hFFFFFFFF},
    {1'b0, 8'hFF, 32'h0,         32'h0},
    {1'b1, 8'h03, 32'h00000042,  32'h0},
    {1'b0, 8'h03, 32'h0,         32'h00000042}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // called at a negedge; returns at a negedge with req low and ack checked low
  task automatic xfer(input logic w, input logic [7:0] a, input logic [31:0] d,
                      input logic wiggle, input logic [7:0] a2, input logic [31:0] d2,
                      output logic [31:0] rd);
    int lat;
    req = 1'b1; wr = w; addr = a; wdata = d; lat = 0;
    do begin
      tick();
      lat++;
      if (wiggle) begin addr = a2; wdata = d2; wr = ~w; end
    end while (!ack && lat < 100);
    check("R2 ack latency", 32'(lat), 32'(LAT + 1));
    rd = rdata;
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R3 ack held", {31'b0, ack}, 32'd1);
      check("R5 rdata steady", rdata, rd);
    end
    req = 1'b0;
    tick();
    check("R4 ack released", {31'b0, ack}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    @(negedge clk);
    repeat (3) tick();
    check("R8 reset ack", {31'b0, ack}, 32'd0);
    check("R8 reset rdata", rdata, 32'd0);
    rst = 1'b0;
    tick();

    // vector table: R6 read/write, R7 unmapped, R2..R5 per transfer
    for (int i = 0; i < 12; i++) begin
      xfer(VEC[i][72], VEC[i][71:64], VEC[i][63:32], 1'b0, 8'h0, 32'h0, rd);
      if (!VEC[i][72]) check($sformatf("R6/R7 read vec %0d", i), rd, VEC[i][31:0]);
      tick();
    end

    // R1/R6: write once, inputs wiggled after capture
    xfer(1'b1, 8'h05, 32'h11112222, 1'b1, 8'h06, 32'h99999999, rd);
    tick();
    xfer(1'b0, 8'h05, 32'h0, 1'b0, 8'h0, 32'h0, rd);
    check("R1 captured write data", rd, 32'h11112222);
    tick();
    xfer(1'b0, 8'h06, 32'h0, 1'b0, 8'h0, 32'h0, rd);
    check("R1 late address not written", rd, 32'h0);
    tick();

    // R1/R5: read address changed mid-request
    xfer(1'b0, 8'h03, 32'h0, 1'b1, 8'h0F, 32'h0, rd);
    check("R1 read uses captured address", rd, 32'h00000042);
    tick();

    // R9: back-to-back requests with one low edge between
    xfer(1'b1, 8'h07, 32'hCAFE0007, 1'b0, 8'h0, 32'h0, rd);
    xfer(1'b0, 8'h07, 32'h0, 1'b0, 8'h0, 32'h0, rd);
    check("R9 back-to-back read", rd, 32'hCAFE0007);
    tick();

    // R8: reset during an open request
    req = 1'b1; wr = 1'b0; addr = 8'h07;
    repeat (LAT + 1) tick();
    check("R8 pre-reset ack", {31'b0, ack}, 32'd1);
    rst = 1'b1;
    tick();
    check("R8 ack cleared", {31'b0, ack}, 32'd0);
    check("R8 rdata cleared", rdata, 32'd0);
    rst = 1'b0; req = 1'b0;
    tick();
    xfer(1'b0, 8'h07, 32'h0, 1'b0, 8'h0, 32'h0, rd);
    check("R8 register cleared 07", rd, 32'h0);
    tick();
    xfer(1'b0, 8'h0F, 32'h0, 1'b0, 8'h0, 32'h0, rd);
    check("R8 register cleared 0F", rd, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule